// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a 36-bit synchronous static RAM. Each word is split into four 9-bit byte lanes, and the ninth bit of every lane is stored like any other data bit. The word count is set by an address-width parameter. Every synchronous pin is captured on the rising clock edge. The captured access passes through an output register, so read data follows the capturing edge by one further edge. After that, a burst delivers one word per cycle.

An access begins when one of two address strobes is asserted. The processor strobe always opens a read. The controller strobe opens a write when any write control is active and a read otherwise. A two-bit burst sequencer then walks the four words of the aligned group. It advances only in cycles where the advance input is low, and it counts in either linear or interleaved order, as chosen by a static mode pin. Writes may be global or per lane. An asynchronous output enable and an asynchronous sleep input gate the output drive flag, and sleep also blocks writes.

The control state machine has two states. ST_OFF means deselected and ST_BURST means a burst is open. The transition "select" moves from either state to ST_BURST on a strobe cycle with all three chip enables true. The transition "deselect" moves to ST_OFF on a strobe cycle with any enable false. "Hold" keeps the state in every cycle without a strobe. Reset enters ST_OFF.

Top module: `sync_burst_sram`

## Requirements
- R1: An access captured at rising edge k loads the output register at edge k+1. q then holds that word and q_drive is 1, provided oe_n is 0 and sleep is 0. The words of a burst appear on consecutive cycles.
- R2: With lin_mode=1, burst step n (n=0..3) accesses the address whose upper bits are those of the start address and whose low two bits are (start[1:0]+n) mod 4.
- R3: With lin_mode=0, the low two bits of burst step n are start[1:0] XOR n, and the upper bits are unchanged.
- R4: In a cycle without a strobe, with a burst open and adv_n=1, the address of the previous access is used again.
- R5: A start through ads_ctrl_n=0 (with ads_proc_n=1) while selected loads a new address. It writes that address when any write control is active and reads it otherwise.
- R6: A start through ads_proc_n=0 with cs_n=0 is always a read. This holds even when write controls are active and even when ads_ctrl_n is also 0.
- R7: ads_proc_n=0 while cs_n=1 and ads_ctrl_n=1 is ignored, and the cycle acts as a burst continuation.
- R8: all_wr_n=0 writes all four lanes, whatever byte_wr_n and byte_we_n are.
- R9: With all_wr_n=1 and byte_wr_n=0, lane i (bits 9i+8..9i of din) is written exactly when byte_we_n[i]=0. With all_wr_n=1 and byte_wr_n=1, nothing is written.
- R10: In a cycle without a strobe, with a burst open and a write control active, the current burst address is written.
- R11: A strobe cycle with cs_n=1 (through ads_ctrl_n), cs_hi=0 or cs_lo_n=1 performs no access. After the next edge q_drive is 0, and later cycles without a strobe do nothing.
- R12: oe_n=1 forces q_drive to 0 at once, with no clock edge needed.
- R13: While sleep=1, q_drive is 0 and writes are blocked. Stored contents survive.
- R14: During and right after reset, q_drive is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, taken on a strobe cycle |
| din | input | 36 | Write data, four 9-bit lanes |
| lin_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| cs_n | input | 1 | Primary chip enable, active low, gates the processor strobe |
| cs_hi | input | 1 | Expansion enable, active high |
| cs_lo_n | input | 1 | Expansion enable, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Lane-write enable, active low |
| byte_we_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| q | output | 36 | Output register contents |
| q_drive | output | 1 | Drive enable for q; 0 stands for high impedance |

## Verification
The assertions assume that lin_mode does not change while a burst is open. They also assume that sleep, once raised around a write, stays high through the edge after the capturing edge, since that is where the write lands. The stimulus changes inputs only on falling edges, holds lin_mode constant within each burst, and keeps sleep high from before the write is captured until after it would have landed. Strobes and enables are always driven to known levels, so the decode never sees unknown values.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [0:0] {
        ST_OFF   = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic cs_hi,
    input  logic cs_lo_n,
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    input  logic adv_n,
    input  logic wr_req,
    output logic load,
    output logic step,
    output op_t  op_nxt
);

    burst_state_t state_q, state_d;
    logic proc_start, start, chosen;

    // a processor strobe only counts while the primary enable is low
    assign proc_start = !ads_proc_n && !cs_n;
    assign start      = !ads_ctrl_n || proc_start;
    assign chosen     = !cs_n && cs_hi && !cs_lo_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (start && chosen) state_d = ST_BURST;     // select
            end
            ST_BURST: begin
                if (start && !chosen) state_d = ST_OFF;      // deselect
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        op_nxt = OP_NONE;
        unique case (state_q)
            ST_OFF: begin
                if (start && chosen) begin
                    load   = 1'b1;
                    op_nxt = (proc_start || !wr_req) ? OP_READ : OP_WRITE;
                end
            end
            ST_BURST: begin
                if (start) begin
                    load   = chosen;
                    if (chosen)
                        op_nxt = (proc_start || !wr_req) ? OP_READ : OP_WRITE;
                end else begin
                    step   = !adv_n;
                    op_nxt = wr_req ? OP_WRITE : OP_READ;
                end
            end
        endcase
    end

    p_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !chosen) |=> (state_q == ST_OFF));

    p_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chosen) |=> (state_q == ST_BURST));

endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq #(
    parameter int ADDR_W = 8,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [SEQ_W-1:0]  cnt_q, cnt_d, low_bits;

    always_comb begin
        base_d = load ? start_addr : base_q;
        if (load)      cnt_d = '0;
        else if (step) cnt_d = cnt_q + SEQ_W'(1);
        else           cnt_d = cnt_q;
        low_bits = linear ? (base_d[SEQ_W-1:0] + cnt_d)
                          : (base_d[SEQ_W-1:0] ^ cnt_d);
        acc_addr = {base_d[ADDR_W-1:SEQ_W], low_bits};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cnt_q) && $stable(base_q)));

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    lin_mode,
    input  logic                    cs_n,
    input  logic                    cs_hi,
    input  logic                    cs_lo_n,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    all_wr_n,
    input  logic                    byte_wr_n,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drive
);

    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  wr_lanes;
    logic              wr_req, load, step;
    op_t               op_nxt, op_q;
    logic [ADDR_W-1:0] acc_addr, addr_q;
    logic [WORD_W-1:0] din_q, rd_data, q_reg;
    logic [LANES-1:0]  lanes_q;
    logic              q_vld;

    // global write overrides the lane selects
    always_comb begin
        if (!all_wr_n)       wr_lanes = '1;
        else if (!byte_wr_n) wr_lanes = ~byte_we_n;
        else                 wr_lanes = '0;
    end
    assign wr_req = |wr_lanes;

    sbsram_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cs_hi      (cs_hi),
        .cs_lo_n    (cs_lo_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .wr_req     (wr_req),
        .load       (load),
        .step       (step),
        .op_nxt     (op_nxt)
    );

    sbsram_seq #(.ADDR_W(ADDR_W), .SEQ_W(BURST_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .linear     (lin_mode),
        .start_addr (addr),
        .acc_addr   (acc_addr)
    );

    // input capture stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            addr_q  <= '0;
            din_q   <= '0;
            lanes_q <= '0;
        end else begin
            op_q    <= op_nxt;
            addr_q  <= acc_addr;
            din_q   <= din;
            lanes_q <= wr_lanes;
        end
    end

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      ((op_q == OP_WRITE) && !sleep),
        .lane_en (lanes_q),
        .addr    (addr_q),
        .wdata   (din_q),
        .rdata   (rd_data)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_reg <= '0;
        end else begin
            q_vld <= (op_q == OP_READ);
            if (op_q == OP_READ) q_reg <= rd_data;
        end
    end

    assign q       = q_reg;
    assign q_drive = q_vld && !oe_n && !sleep;

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ) |=> q_vld);

    p_proc_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !cs_n && cs_hi && !cs_lo_n) |=> (op_q == OP_READ));

    p_ctrl_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_ctrl_n && ads_proc_n && !cs_n && cs_hi && !cs_lo_n && !all_wr_n)
        |=> (op_q == OP_WRITE));

    p_idle_after_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_NONE) |=> !q_vld);

endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic [35:0] din;
    logic        lin_mode, cs_n, cs_hi, cs_lo_n, ads_proc_n, ads_ctrl_n, adv_n;
    logic        all_wr_n, byte_wr_n, oe_n, sleep;
    logic [3:0]  byte_we_n;
    logic [35:0] q;
    logic        q_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [35:0] model [256];

    always #10 clk = ~clk;

    sync_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .lin_mode(lin_mode),
        .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .ads_proc_n(ads_proc_n),
        .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .all_wr_n(all_wr_n),
        .byte_wr_n(byte_wr_n), .byte_we_n(byte_we_n), .oe_n(oe_n), .sleep(sleep),
        .q(q), .q_drive(q_drive)
    );

    function automatic logic [35:0] pat(input int a, input int salt);
        logic [35:0] v;
        v = 36'(a * 40503 + salt * 977) ^ 36'h5_A5C3_3C96;
        return v;
    endfunction

    function automatic logic [7:0] seq_addr(input logic [7:0] b, input int k, input logic lin);
        logic [1:0] o;
        o = lin ? (b[1:0] + 2'(k)) : (b[1:0] ^ 2'(k));
        return {b[7:2], o};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                          input logic [3:0] m);
        logic [35:0] r;
        r = old_w;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pins_idle();
        ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1;
        cs_n = 0; cs_hi = 1; cs_lo_n = 0;
        all_wr_n = 1; byte_wr_n = 1; byte_we_n = 4'hF;
    endtask

    task automatic expect_word(input logic [7:0] a, input string req);
        chk(req, {35'd0, q_drive}, 36'd1);
        chk(req, q, model[a]);
    endtask

    // R1 latency and R2/R3 order; processor start also carries write pins (R6)
    task automatic rd_burst(input logic [7:0] b, input logic lin, input logic via_proc,
                            input string req);
        @(negedge clk); pins_idle(); lin_mode = lin; addr = b;
        if (via_proc) begin ads_proc_n = 0; ads_ctrl_n = 0; all_wr_n = 0; din = ~model[b]; end
        else ads_ctrl_n = 0;
        @(negedge clk); pins_idle(); adv_n = 0;
        @(negedge clk); expect_word(seq_addr(b, 0, lin), req); pins_idle(); adv_n = 0;
        @(negedge clk); expect_word(seq_addr(b, 1, lin), req); pins_idle(); adv_n = 0;
        @(negedge clk); expect_word(seq_addr(b, 2, lin), req); pins_idle();
        @(negedge clk); expect_word(seq_addr(b, 3, lin), req);
    endtask

    task automatic wr_one(input logic [7:0] a, input logic [35:0] d, input logic gw_n,
                          input logic bwe_n, input logic [3:0] be_n);
        logic [3:0] m;
        @(negedge clk); pins_idle(); addr = a; ads_ctrl_n = 0; din = d;
        all_wr_n = gw_n; byte_wr_n = bwe_n; byte_we_n = be_n;
        m = !gw_n ? 4'hF : (!bwe_n ? ~be_n : 4'h0);
        if (!sleep) model[a] = merge(model[a], d, m);
        @(negedge clk); pins_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        pins_idle(); addr = 0; din = 0; lin_mode = 1; oe_n = 0; sleep = 0; rst_n = 0;
        for (int i = 0; i < 256; i++) model[i] = 36'h0;
        repeat (3) @(negedge clk);
        chk("R14 drive in reset", {35'd0, q_drive}, 36'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R14 drive after reset", {35'd0, q_drive}, 36'd0);

        // R8: global write fill with lane pins inactive
        for (int a = 0; a < 256; a++) wr_one(8'(a), pat(a, 1), 1'b0, 1'b1, 4'hF);

        // R2 R3 R1 R5 R6 sweep
        for (int b = 0; b < 16; b++)
            for (int lin = 0; lin < 2; lin++)
                for (int p = 0; p < 2; p++)
                    rd_burst(8'(b * 5), 1'(lin), 1'(p),
                             p ? (lin ? "R6 R2 proc linear" : "R6 R3 proc interleave")
                               : (lin ? "R5 R2 ctrl linear" : "R5 R3 ctrl interleave"));

        // R9 lane writes, every mask
        for (int m = 0; m < 16; m++)
            wr_one(8'(100 + m), pat(m, 7), 1'b1, 1'b0, ~4'(m));
        for (int g = 0; g < 4; g++) rd_burst(8'(100 + 4 * g), 1'b1, 1'b0, "R9 lane mask");
        // R9 lane pins without lane enable: nothing written
        wr_one(8'd120, pat(120, 9), 1'b1, 1'b1, 4'h0);
        // R8 global overrides partial lane selects
        wr_one(8'd121, pat(121, 9), 1'b0, 1'b0, 4'b1110);
        rd_burst(8'd120, 1'b1, 1'b0, "R8 R9 override and no-write");

        // R10 burst write, interleaved from 130
        @(negedge clk); pins_idle(); lin_mode = 0; addr = 8'd130; ads_ctrl_n = 0;
        all_wr_n = 0; din = pat(130, 3); model[130] = din;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk); pins_idle(); adv_n = 0; all_wr_n = 0; din = pat(k, 3);
            model[seq_addr(8'd130, k, 1'b0)] = din;
        end
        @(negedge clk); pins_idle();
        rd_burst(8'd128, 1'b1, 1'b0, "R10 burst write");

        // R4 suspend: 40, 40, 41
        @(negedge clk); pins_idle(); lin_mode = 1; addr = 8'd40; ads_ctrl_n = 0;
        @(negedge clk); pins_idle();
        @(negedge clk); expect_word(8'd40, "R4 first"); pins_idle(); adv_n = 0;
        @(negedge clk); expect_word(8'd40, "R4 repeat"); pins_idle();
        @(negedge clk); expect_word(8'd41, "R4 resume");

        // R7 processor strobe ignored with cs_n high: 44, 45, 46
        @(negedge clk); pins_idle(); addr = 8'd44; ads_ctrl_n = 0;
        @(negedge clk); pins_idle(); ads_proc_n = 0; cs_n = 1; adv_n = 0; addr = 8'd0;
        @(negedge clk); expect_word(8'd44, "R7 first"); pins_idle(); adv_n = 0;
        @(negedge clk); expect_word(8'd45, "R7 continued"); pins_idle();
        @(negedge clk); expect_word(8'd46, "R7 next");

        // R11 deselect after one cycle
        @(negedge clk); pins_idle(); addr = 8'd48; ads_ctrl_n = 0;
        @(negedge clk); pins_idle(); ads_ctrl_n = 0; cs_n = 1;
        @(negedge clk); expect_word(8'd48, "R11 before deselect"); pins_idle(); adv_n = 0;
        @(negedge clk); chk("R11 drive off", {35'd0, q_drive}, 36'd0); pins_idle(); adv_n = 0;
        @(negedge clk); chk("R11 stays off", {35'd0, q_drive}, 36'd0);
        // R11 writes under expansion deselect are dropped
        @(negedge clk); pins_idle(); addr = 8'd50; ads_ctrl_n = 0; cs_hi = 0; all_wr_n = 0; din = ~model[50];
        @(negedge clk); pins_idle(); adv_n = 0; all_wr_n = 0;
        @(negedge clk); pins_idle(); addr = 8'd51; ads_ctrl_n = 0; cs_lo_n = 1; all_wr_n = 0; din = ~model[51];
        @(negedge clk); pins_idle(); adv_n = 0; all_wr_n = 0;
        @(negedge clk); chk("R11 no access", {35'd0, q_drive}, 36'd0); pins_idle();
        rd_burst(8'd48, 1'b1, 1'b0, "R11 contents kept");

        // R12 asynchronous output enable
        @(negedge clk); pins_idle(); addr = 8'd52; ads_ctrl_n = 0;
        @(negedge clk); pins_idle();
        @(negedge clk); oe_n = 1; #1;
        chk("R12 oe off", {35'd0, q_drive}, 36'd0);
        oe_n = 0; #1;
        chk("R12 oe on", {35'd0, q_drive}, 36'd1);
        chk("R12 data", q, model[52]);

        // R13 sleep blocks writes and drive
        @(negedge clk); sleep = 1;
        wr_one(8'd60, ~model[60], 1'b0, 1'b1, 4'hF);
        @(negedge clk); pins_idle(); addr = 8'd56; ads_ctrl_n = 0;
        @(negedge clk); pins_idle();
        @(negedge clk); chk("R13 drive off", {35'd0, q_drive}, 36'd0);
        @(negedge clk); sleep = 0;
        rd_burst(8'd56, 1'b1, 1'b0, "R13 contents kept");
        rd_burst(8'd60, 1'b1, 1'b0, "R13 write blocked");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule